// File: doc/BRIEF.md
# Keyed Reload Watchdog Timer

This block guards a processor against running astray. A fixed divider first turns the system clock into machine-cycle ticks. A power-of-two prescaler then slows those ticks further. Behind them sits a count register that steps upward. When the count passes its all-ones value, the block raises a one-clock reset request. After that it falls back to the disabled state it had after power-on.

Software starts the watchdog by setting an arm bit in the control register. Software keeps the watchdog from firing by reloading the count, but a reload is taken only while the arm bit is set. Each accepted reload clears the arm bit again, so a stray store to the count register cannot keep a runaway program alive. Turning the watchdog off takes a second, deliberate act: one particular key value written to its own register.

The time to a reset is (2^CNT_W − loaded value) × MC_DIV × 2^PRE_W clocks. With the defaults this is 12 × 2048 clocks per step, which at 12 MHz is 2.048 ms per step.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, rst_req is 0 and both the count and the status read as 0. The register map and read encodings are:
  - Address 0 is control/status. A read returns the arm bit in bit 0 and the running bit in bit 1.
  - Address 1 is the count. A read returns the current count.
  - Address 2 is the key register. A read returns 0.
- R2: A write to address 0 with bit 0 set sets both the arm bit and the running bit.
- R3: A write to address 1 while the arm bit is clear is ignored. It changes neither the count nor the time at which the next reset request comes.
- R4: A write to address 1 while the arm bit is set does three things. It loads the written value into the count, clears the arm bit, and restarts both dividers from zero.
- R5: While running, the count rises by one every MC_DIV × 2^PRE_W clocks, measured from the load or from the start.
- R6: rst_req is high for exactly one clock. It goes high (2^CNT_W − V) × MC_DIV × 2^PRE_W clocks after the clock edge that loaded V.
- R7: In the cycle rst_req is high, the block is already back in its power-on state: not running, not armed, and count 0. No further request follows unless software starts the watchdog again.
- R8: Writing KEY_VALUE (default 0x55) to address 2 has these effects:
  - It stops the watchdog and clears the arm bit.
  - It holds the count.
  - No reset request follows.
- R9: Writing any other value to address 2 changes neither the status nor the time of the next reset request.
- R10: After a key stop, setting bit 0 at address 0 starts the watchdog again. Counting resumes from the held count, with both dividers starting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 2 | Register address for both write and read |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-clock system reset request |

## Verification
All timing is counted from the clock edge that accepts a write. A count step is due MC_DIV × 2^PRE_W edges after a load, and the reset request is due (2^CNT_W − V) of those periods after the load. The request is registered, so it is seen after exactly that edge. Register reads are combinational, so they are checked in the same half-cycle as the edge of interest.

The bench records the edge number of every write. From it, the bench queues the exact cycles where rst_req must be low, high, and low again. A monitor compares these against rst_req at each falling edge. Cycles where a request must not appear after a key stop or an ignored write are checked the same way.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOAD = 2'd1,
    REG_KEY  = 2'd2
  } wdt_reg_e;

  localparam int STAT_ARM_BIT = 0;
  localparam int STAT_RUN_BIT = 1;
endpackage

// File: rtl/keyed_wdt_rst_sync.sv
module keyed_wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/keyed_wdt_moddiv.sv
module keyed_wdt_moddiv #(
  parameter int MOD = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic wrap
);
  localparam int CW = (MOD > 1) ? $clog2(MOD) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign wrap = en && (cnt_q == CW'(MOD - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int MC_DIV = 12,
  parameter int PRE_W  = 11,
  parameter int CNT_W  = 8,
  parameter logic [CNT_W-1:0] KEY_VALUE = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             rst_req
);
  localparam int PRE_MOD = 1 << PRE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic srst_n;
  logic arm_q, arm_d;
  logic run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic rst_req_d;

  logic wr_ctrl, wr_load, wr_key;
  logic load_ok, key_ok, cnt_tick, ovf, div_clr;
  logic mc_wrap, pre_wrap;

  keyed_wdt_rst_sync u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // Machine-cycle divider followed by the prescaler.
  keyed_wdt_moddiv #(.MOD(MC_DIV)) u_mcdiv (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (run_q),
    .clr   (div_clr),
    .wrap  (mc_wrap)
  );

  keyed_wdt_moddiv #(.MOD(PRE_MOD)) u_pre (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (mc_wrap),
    .clr   (div_clr),
    .wrap  (pre_wrap)
  );

  always_comb begin
    wr_ctrl  = bus_wr && (wdt_reg_e'(bus_addr) == REG_CTRL);
    wr_load  = bus_wr && (wdt_reg_e'(bus_addr) == REG_LOAD);
    wr_key   = bus_wr && (wdt_reg_e'(bus_addr) == REG_KEY);
    load_ok  = wr_load && arm_q;
    key_ok   = wr_key && (bus_wdata == KEY_VALUE);
    cnt_tick = pre_wrap && !load_ok && !key_ok;
    ovf      = cnt_tick && (cnt_q == CNT_MAX);
    div_clr  = load_ok || key_ok || ovf;
  end

  // Next-state logic
  always_comb begin
    run_d     = run_q;
    arm_d     = arm_q;
    cnt_d     = cnt_q;
    rst_req_d = ovf;

    if (key_ok) begin
      run_d = 1'b0;
      arm_d = 1'b0;
    end else if (ovf) begin
      run_d = 1'b0;
      arm_d = 1'b0;
      cnt_d = '0;
    end else if (load_ok) begin
      arm_d = 1'b0;
      cnt_d = bus_wdata;
    end else begin
      if (wr_ctrl) begin
        arm_d = bus_wdata[0];
        if (bus_wdata[0]) run_d = 1'b1;
      end
      if (cnt_tick) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q   <= 1'b0;
      arm_q   <= 1'b0;
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      run_q   <= run_d;
      arm_q   <= arm_d;
      cnt_q   <= cnt_d;
      rst_req <= rst_req_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (wdt_reg_e'(bus_addr))
      REG_CTRL: begin
        bus_rdata[STAT_ARM_BIT] = arm_q;
        bus_rdata[STAT_RUN_BIT] = run_q;
      end
      REG_LOAD: bus_rdata = cnt_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] KEY_VALUE = 8'h55
) (
  input logic             clk,
  input logic             srst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             arm_q,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rst_req
);
  logic is_ctrl, is_load, is_key;
  assign is_ctrl = bus_wr && (wdt_reg_e'(bus_addr) == REG_CTRL);
  assign is_load = bus_wr && (wdt_reg_e'(bus_addr) == REG_LOAD);
  assign is_key  = bus_wr && (wdt_reg_e'(bus_addr) == REG_KEY);

  assert_arm_start_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (is_ctrl && bus_wdata[0]) |=> ((run_q && arm_q) || rst_req));

  assert_ignored_load_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (is_load && !arm_q && !run_q) |=> $stable(cnt_q));

  assert_load_arm_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (is_load && arm_q) |=> (!arm_q && cnt_q == $past(bus_wdata)));

  assert_step_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (run_q && !bus_wr) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1) || rst_req));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |=> !rst_req);

  assert_pulse_src_R6: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> $past(run_q));

  assert_post_ovf_R7: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> (!run_q && !arm_q && cnt_q == '0));

  assert_key_off_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (is_key && bus_wdata == KEY_VALUE) |=> (!run_q && !arm_q && !rst_req));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .KEY_VALUE(KEY_VALUE)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .arm_q     (arm_q),
  .run_q     (run_q),
  .cnt_q     (cnt_q),
  .rst_req   (rst_req)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int MC_DIV = 3;
  localparam int PRE_W  = 2;
  localparam int STEP   = MC_DIV * (1 << PRE_W);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       rst_req;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  keyed_wdt #(.MC_DIV(MC_DIV), .PRE_W(PRE_W), .CNT_W(8), .KEY_VALUE(8'h55)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares rst_req against the queued expectations
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      cur = exp_q.pop_front();
      n_chk++;
      if (cur.due != cyc || rst_req !== cur.val) begin
        n_fail++;
        $display("FAIL %s: rst_req at cycle %0d actual %b expected %b (due %0d)",
                 cur.tag, cyc, rst_req, cur.val, cur.due);
      end
    end
  end

  task automatic expect_req(input int due, input logic val, input string tag);
    exp_t it;
    it.due = due; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e_no);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    e_no = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: read addr %0d at cycle %0d actual %h expected %h",
               tag, a, cyc, bus_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung at cycle %0d actual running expected finished", cyc);
    finish_run();
  end

  initial begin
    int l1, l2, l3, e, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    n_chk++;
    if (rst_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: rst_req actual %b expected 0", rst_req);
    end
    rd_check(2'd0, 8'h00, "R1");
    rd_check(2'd1, 8'h00, "R1");
    rd_check(2'd2, 8'h00, "R1");

    // R2: start
    wr(2'd0, 8'h01, e);
    rd_check(2'd0, 8'h03, "R2");

    // R4: armed load, then R5 stepping, R3 ignored load, R6 pulse
    wr(2'd1, 8'hF0, l1);
    expect_req(l1 + 16 * STEP - 1, 1'b0, "R6");
    expect_req(l1 + 16 * STEP,     1'b1, "R6");
    expect_req(l1 + 16 * STEP + 1, 1'b0, "R6");
    rd_check(2'd1, 8'hF0, "R4");
    rd_check(2'd0, 8'h02, "R4");
    wait_until(l1 + STEP - 1);
    rd_check(2'd1, 8'hF0, "R5");
    wait_until(l1 + STEP);
    rd_check(2'd1, 8'hF1, "R5");
    wr(2'd1, 8'h10, k);
    rd_check(2'd1, 8'hF1, "R3");
    rd_check(2'd0, 8'h02, "R3");
    wait_until(l1 + 16 * STEP);
    rd_check(2'd0, 8'h00, "R7");
    rd_check(2'd1, 8'h00, "R7");
    expect_req(l1 + 16 * STEP + STEP, 1'b0, "R7");
    wait_until(l1 + 16 * STEP + STEP + 2);

    // R9: wrong key has no effect
    wr(2'd0, 8'h01, e);
    wr(2'd1, 8'hFE, l2);
    expect_req(l2 + 2 * STEP - 1, 1'b0, "R9");
    expect_req(l2 + 2 * STEP,     1'b1, "R9");
    expect_req(l2 + 2 * STEP + 1, 1'b0, "R9");
    wr(2'd2, 8'h12, k);
    rd_check(2'd0, 8'h02, "R9");
    rd_check(2'd1, 8'hFE, "R9");
    wait_until(l2 + 2 * STEP + 3);

    // R8: correct key stops it
    wr(2'd0, 8'h01, e);
    wr(2'd1, 8'hFF, l3);
    wr(2'd2, 8'h55, k);
    expect_req(l3 + STEP,     1'b0, "R8");
    expect_req(l3 + 2 * STEP, 1'b0, "R8");
    rd_check(2'd0, 8'h00, "R8");
    wait_until(l3 + 2 * STEP + 6);
    rd_check(2'd1, 8'hFF, "R8");

    // R10: restart after key stop
    wr(2'd0, 8'h01, e);
    rd_check(2'd0, 8'h03, "R10");
    expect_req(e + STEP - 1, 1'b0, "R10");
    expect_req(e + STEP,     1'b1, "R10");
    expect_req(e + STEP + 1, 1'b0, "R10");
    wait_until(e + STEP + 2);
    rd_check(2'd0, 8'h00, "R10");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule